// File: doc/BRIEF.md
# CPU Run-Mode Controller with Automatic Start

This block produces the two active-low mode lines, `clear_n` and `wait_n`, that an 8-bit processor decodes into one of four operating states: load, reset, pause and run. Operators and other logic ask for a state by pulling one of four request lines low for a short time. Every request line is shared by several drivers and behaves as a wired-AND. The chosen state lives in two set/reset storage elements, one for each output line. It stays in place after the request pulse is gone.

A power-on reset (`por_n`) or a pushbutton (`btn_n`) starts a reset pulse of guaranteed length. While that pulse lasts, the controller is held in the reset state. When the pulse ends, an internal one-shot issues a run request by itself, so the processor starts without an operator. Both internal pulses are also driven out as active-low lines for neighbouring logic.

The request inputs and the pushbutton are asynchronous. Each passes through a two-flop synchroniser. Only a falling edge of a synchronised request line counts as a request.

Top module: `run_mode_ctrl`

## Requirements
- R1: While `por_n` is low: `clear_n`=0, `wait_n`=1, `rst_pulse_n`=0 and `run_pulse_n`=1.
- R2: After `por_n` rises between two clock edges, `rst_pulse_n` stays low through STRETCH (default 16) rising edges and is high after the STRETCH-th edge.
- R3: `run_pulse_n` goes low after the first rising edge that follows the end of the stretched reset. It stays low for exactly 2 cycles. The outputs show run mode after the second of those edges.
- R4: The output encodings are {clear_n,wait_n}: load = 00, reset = 01, pause = 10, run = 11.
- R5: A request line falling between clock edges changes the outputs after the third rising edge, not the second. The mode then persists after the line returns high.
- R6: A request line held low acts only once. Holding it, or releasing it (a rising edge), has no effect on the mode.
- R7: A request line is the AND of its NSRC driver inputs, so any single driver pulling low makes the request.
- R8: Requests seen in the same cycle resolve by priority reset > load > pause > run.
- R9: `btn_n` low forces reset mode with `rst_pulse_n`=0. After `btn_n` is released between edges, `rst_pulse_n` rises after STRETCH+2 rising edges, and the automatic run of R3 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| btn_n | input | 1 | Pushbutton reset, asynchronous, active low |
| run_n | input | NSRC | Run request drivers, wired-AND, active low |
| reset_n | input | NSRC | Reset request drivers, wired-AND, active low |
| load_n | input | NSRC | Load request drivers, wired-AND, active low |
| pause_n | input | NSRC | Pause request drivers, wired-AND, active low |
| clear_n | output | 1 | Processor CLEAR mode line |
| wait_n | output | 1 | Processor WAIT mode line |
| rst_pulse_n | output | 1 | Stretched reset pulse, active low |
| run_pulse_n | output | 1 | Automatic run one-shot, active low |

## Verification
The properties assume the following about the inputs:
- `por_n` is the only asynchronous reset, and it returns high away from a clock edge.
- Each request stays low for at least one full clock period, so the synchroniser catches it.
- Requests meant to be separate are far enough apart that their synchronised edges land in different cycles.

The stimulus meets these assumptions as follows:
- All lines change on the falling clock edge.
- Each request is held low for three cycles and is followed by at least three idle cycles.
- Requests meant to collide are driven in the same cycle, so their edges coincide on purpose.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  typedef struct packed {
    logic clear_n;
    logic wait_n;
  } mode_lines_t;

  localparam mode_lines_t MODE_LOAD  = '{clear_n: 1'b0, wait_n: 1'b0};
  localparam mode_lines_t MODE_RESET = '{clear_n: 1'b0, wait_n: 1'b1};
  localparam mode_lines_t MODE_PAUSE = '{clear_n: 1'b1, wait_n: 1'b0};
  localparam mode_lines_t MODE_RUN   = '{clear_n: 1'b1, wait_n: 1'b1};

  // Returns {valid, clear_n, wait_n}; reset > load > pause > run.
  function automatic logic [2:0] mode_pick(input logic ev_rst, input logic ev_load,
                                           input logic ev_pause, input logic ev_run);
    logic [2:0] r;
    if (ev_rst)        r = {1'b1, MODE_RESET};
    else if (ev_load)  r = {1'b1, MODE_LOAD};
    else if (ev_pause) r = {1'b1, MODE_PAUSE};
    else if (ev_run)   r = {1'b1, MODE_RUN};
    else               r = 3'b000;
    return r;
  endfunction

endpackage

// File: rtl/mrc_sync.sv
module mrc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/mrc_fall.sv
module mrc_fall #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] lvl_n,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) prev_n <= '1;
    else         prev_n <= lvl_n;
  end
  assign fall = prev_n & ~lvl_n;
endmodule

// File: rtl/mrc_stretch.sv
module mrc_stretch #(
  parameter int STRETCH = 16,
  parameter int RUN_LEN = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic btn_lvl_n,
  output logic rst_active,
  output logic run_active
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(STRETCH);
  localparam logic [RW-1:0] RUN_FULL = RW'(RUN_LEN);

  logic [CW-1:0] cnt;
  logic [RW-1:0] run_cnt;
  logic          rst_d;
  logic          rst_end;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)           cnt <= CNT_FULL;
    else if (!btn_lvl_n)   cnt <= CNT_FULL;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign rst_active = (cnt != '0);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_d <= 1'b1;
    else         rst_d <= rst_active;
  end

  assign rst_end = rst_d & ~rst_active;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            run_cnt <= '0;
    else if (rst_end)       run_cnt <= RUN_FULL;
    else if (run_cnt != '0) run_cnt <= run_cnt - 1'b1;
  end

  assign run_active = (run_cnt != '0);
endmodule

// File: rtl/mrc_latch.sv
module mrc_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    q <= RST_VAL;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end
endmodule

// File: rtl/run_mode_ctrl.sv
module run_mode_ctrl
  import mrc_pkg::*;
#(
  parameter int NSRC    = 2,
  parameter int STRETCH = 16
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            btn_n,
  input  logic [NSRC-1:0] run_n,
  input  logic [NSRC-1:0] reset_n,
  input  logic [NSRC-1:0] load_n,
  input  logic [NSRC-1:0] pause_n,
  output logic            clear_n,
  output logic            wait_n,
  output logic            rst_pulse_n,
  output logic            run_pulse_n
);
  localparam int NREQ = 4;  // [3]=reset [2]=load [1]=pause [0]=run
  localparam int NIN  = NREQ + 1;

  logic [NIN-1:0]  raw_n, sync_n;
  logic [NREQ-1:0] lvl_n, fall;
  logic            rst_active, run_active;
  logic            ev_rst, ev_load, ev_pause, ev_run, any_ev;
  logic [2:0]      pick;

  // Wired-AND of every driver on each shared line.
  assign raw_n = {btn_n, &reset_n, &load_n, &pause_n, &run_n};

  mrc_sync #(.W(NIN)) u_sync (
    .clk(clk), .arst_n(por_n), .d(raw_n), .q(sync_n)
  );

  mrc_stretch #(.STRETCH(STRETCH), .RUN_LEN(2)) u_stretch (
    .clk(clk), .arst_n(por_n), .btn_lvl_n(sync_n[NREQ]),
    .rst_active(rst_active), .run_active(run_active)
  );

  // The one-shot joins the run line like any other driver.
  assign lvl_n = {sync_n[3], sync_n[2], sync_n[1], sync_n[0] & ~run_active};

  mrc_fall #(.W(NREQ)) u_fall (
    .clk(clk), .arst_n(por_n), .lvl_n(lvl_n), .fall(fall)
  );

  assign ev_rst   = fall[3] | rst_active;
  assign ev_load  = fall[2];
  assign ev_pause = fall[1];
  assign ev_run   = fall[0];
  assign any_ev   = ev_rst | ev_load | ev_pause | ev_run;

  assign pick = mode_pick(ev_rst, ev_load, ev_pause, ev_run);

  mrc_latch #(.RST_VAL(1'b0)) u_clear (
    .clk(clk), .arst_n(por_n),
    .set_i(pick[2] & pick[1]), .clr_i(pick[2] & ~pick[1]), .q(clear_n)
  );

  mrc_latch #(.RST_VAL(1'b1)) u_wait (
    .clk(clk), .arst_n(por_n),
    .set_i(pick[2] & pick[0]), .clr_i(pick[2] & ~pick[0]), .q(wait_n)
  );

  assign rst_pulse_n = ~rst_active;
  assign run_pulse_n = ~run_active;
endmodule

// File: rtl/mrc_chk.sv
module mrc_chk (
  input logic clk,
  input logic por_n,
  input logic clear_n,
  input logic wait_n,
  input logic rst_pulse_n,
  input logic run_pulse_n,
  input logic any_ev,
  input logic ev_rst,
  input logic ev_load
);
  AST_RESET_FORCES_MODE: assert property (@(posedge clk) disable iff (!por_n)
    !rst_pulse_n |=> (!clear_n && wait_n));  // R9

  AST_AUTORUN_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_pulse_n) |=> $fell(run_pulse_n));  // R3

  AST_AUTORUN_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(run_pulse_n) |=> (!run_pulse_n ##1 run_pulse_n));  // R3

  AST_PULSES_DISJOINT: assert property (@(posedge clk) disable iff (!por_n)
    !(!rst_pulse_n && !run_pulse_n));  // R3

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    !any_ev |=> $stable({clear_n, wait_n}));  // R6

  AST_LOAD_BEATS_LOWER: assert property (@(posedge clk) disable iff (!por_n)
    (ev_load && !ev_rst) |=> (!clear_n && !wait_n));  // R8
endmodule

bind run_mode_ctrl mrc_chk i_mrc_chk (
  .clk(clk), .por_n(por_n), .clear_n(clear_n), .wait_n(wait_n),
  .rst_pulse_n(rst_pulse_n), .run_pulse_n(run_pulse_n),
  .any_ev(any_ev), .ev_rst(ev_rst), .ev_load(ev_load)
);

// File: tb/test_run_mode_ctrl.sv
`timescale 1ns/1ps
module test_run_mode_ctrl;
  localparam int NSRC    = 2;
  localparam int STRETCH = 16;
  localparam logic [1:0] LOAD = 2'b00, RESET = 2'b01, PAUSE = 2'b10, RUN = 2'b11;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic btn_n = 1'b1;
  logic [NSRC-1:0] run_n = '1, reset_n = '1, load_n = '1, pause_n = '1;
  logic clear_n, wait_n, rst_pulse_n, run_pulse_n;

  int total = 0;
  int bad = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];
  event       sb_go;

  always #4 clk = ~clk;

  run_mode_ctrl #(.NSRC(NSRC), .STRETCH(STRETCH)) i_run_mode_ctrl (
    .clk(clk), .por_n(por_n), .btn_n(btn_n), .run_n(run_n), .reset_n(reset_n),
    .load_n(load_n), .pause_n(pause_n), .clear_n(clear_n), .wait_n(wait_n),
    .rst_pulse_n(rst_pulse_n), .run_pulse_n(run_pulse_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] mode();
    return {clear_n, wait_n};
  endfunction

  // lines: [3]=reset [2]=load [1]=pause [0]=run, driven low on driver src.
  task automatic drive(input logic [3:0] lines, input int src, input logic lv);
    if (lines[3]) reset_n[src] = lv;
    if (lines[2]) load_n[src]  = lv;
    if (lines[1]) pause_n[src] = lv;
    if (lines[0]) run_n[src]   = lv;
  endtask

  task automatic issue(input logic [3:0] lines, input int src,
                       input logic [1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    drive(lines, src, 1'b0);
    repeat (3) @(negedge clk);
    drive(lines, src, 1'b1);
    repeat (3) @(negedge clk);
    -> sb_go;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(sb_go);
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {6'd0, mode()}, {6'd0, e});
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    check("R1 clear_n in reset", {7'd0, clear_n}, 8'd0);
    check("R1 wait_n in reset", {7'd0, wait_n}, 8'd1);
    check("R1 rst_pulse_n low", {7'd0, rst_pulse_n}, 8'd0);
    check("R1 run_pulse_n idle", {7'd0, run_pulse_n}, 8'd1);

    por_n = 1'b1;  // released at a falling edge
    repeat (STRETCH - 1) @(negedge clk);
    check("R2 stretch still low", {7'd0, rst_pulse_n}, 8'd0);
    @(negedge clk);
    check("R2 stretch ends", {7'd0, rst_pulse_n}, 8'd1);
    check("R3 no run yet", {7'd0, run_pulse_n}, 8'd1);
    @(negedge clk);
    check("R3 one-shot low", {7'd0, run_pulse_n}, 8'd0);
    check("R3 still reset mode", {6'd0, mode()}, {6'd0, RESET});
    @(negedge clk);
    check("R3 one-shot 2nd cycle", {7'd0, run_pulse_n}, 8'd0);
    check("R3 run mode", {6'd0, mode()}, {6'd0, RUN});
    @(negedge clk);
    check("R3 one-shot done", {7'd0, run_pulse_n}, 8'd1);
    repeat (3) @(negedge clk);

    // R5 latency: fall between edges, visible after third edge.
    load_n[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 not after two edges", {6'd0, mode()}, {6'd0, RUN});
    @(negedge clk);
    check("R5 load after three edges R4", {6'd0, mode()}, {6'd0, LOAD});
    load_n[0] = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 load persists", {6'd0, mode()}, {6'd0, LOAD});

    issue(4'b1000, 1, RESET, "R7 R4 reset via driver 1");
    issue(4'b0001, 1, RUN,   "R7 run via driver 1");
    issue(4'b0010, 0, PAUSE, "R4 pause");
    issue(4'b1100, 0, RESET, "R8 reset over load");
    issue(4'b0110, 1, LOAD,  "R8 load over pause");
    issue(4'b0011, 0, PAUSE, "R8 pause over run");
    issue(4'b0001, 0, RUN,   "R8 run alone");

    // R6: a held run line fires once only.
    issue(4'b0010, 0, PAUSE, "R6 pause before hold");
    @(negedge clk);
    run_n[0] = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 held run fires once", {6'd0, mode()}, {6'd0, RUN});
    issue(4'b0010, 1, PAUSE, "R6 pause while run held");
    repeat (10) @(negedge clk);
    check("R6 held run no refire", {6'd0, mode()}, {6'd0, PAUSE});
    run_n[0] = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 run release ignored", {6'd0, mode()}, {6'd0, PAUSE});

    // R9: pushbutton.
    btn_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 button forces reset", {6'd0, mode()}, {6'd0, RESET});
    check("R9 rst_pulse_n low", {7'd0, rst_pulse_n}, 8'd0);
    repeat (20) @(negedge clk);
    btn_n = 1'b1;
    n = 0;
    while (rst_pulse_n == 1'b0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check("R9 stretch after button", 8'(n), 8'(STRETCH + 2));
    n = 0;
    @(negedge clk);
    while (run_pulse_n == 1'b0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R3 one-shot width after button", 8'(n), 8'd2);
    check("R9 run after button", {6'd0, mode()}, {6'd0, RUN});

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule